// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a parameterised number of interrupt lines (up to 32) and turns them into one interrupt request for a processor. Each line is fixed at build time as edge sensitive or level sensitive by a kind mask. An edge line latches on a rising edge. A level line latches while it is high. The latched status is masked by an enable register, and a priority encoder reports the lowest-numbered pending line as a vector number.

Software reaches eight 32-bit registers over a plain synchronous register port. That port has a word address, write data, a write strobe, a read strobe and registered read data. It has no stream data, so it has no valid/ready pair. A write takes effect on the clock edge where the write strobe is high. Read data is captured on the edge where the read strobe is high, reflects the register values just before that edge, and holds until the next read.

The usual service loop is short: read the vector, handle that line, acknowledge it, and repeat until the vector reads all ones. Dedicated set-enable and clear-enable words let software change one line's mask without a read-modify-write.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and the two master bits are zero, `irq_req` is low, and the vector word reads 0xFFFFFFFF.
- R2: Status (word 0) latches line i when it rises, if bit i of `KIND_MASK` is 1 (edge sensitive). It latches while the line is high if that bit is 0 (level sensitive). Mask bits at or above `NUM_IN` have no effect.
- R3: A write to enable (word 2) loads it. Each 1 written to set-enable (word 4) sets the matching enable bit, and each 1 written to clear-enable (word 5) clears it. Zero bits leave the enable register unchanged. Enable reads back only its low `NUM_IN` bits.
- R4: Pending (word 1) reads status AND enable. After enable is written with 0, pending reads 0.
- R5: Each 1 written to acknowledge (word 3) clears that status bit. Writing 0xFFFFFFFF clears every status bit.
- R6: Vector (word 6) reads the index of the lowest-numbered pending bit, so a lower index has higher priority. It reads 0xFFFFFFFF when nothing is pending.
- R7: Master (word 7) holds two bits: bit 0 is the global enable and bit 1 is the output enable. `irq_req` is high only when both bits are 1 and at least one bit is pending.
- R8: If a level-sensitive line is acknowledged while it is still high, its status bit still reads 1 afterwards.
- R9: A rising edge on an edge-sensitive line in the same cycle as an acknowledge of that bit leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IN | Interrupt lines, synchronous to clk |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume the interrupt lines are already synchronous to `clk` and that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume the address and write data are stable on every edge where a strobe is high. The bench drives all of these inputs on the falling edge and raises at most one strobe per cycle, so every edge sees settled values. It makes an acknowledge coincide with an input edge exactly once, on purpose, to exercise the edge-wins rule.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 3'd0,
    RA_PEND   = 3'd1,
    RA_ENABLE = 3'd2,
    RA_ACK    = 3'd3,
    RA_SETEN  = 3'd4,
    RA_CLREN  = 3'd5,
    RA_VECTOR = 3'd6,
    RA_MASTER = 3'd7
  } reg_addr_e;

  localparam logic [REG_W-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] ack_clr,
  output logic [NUM_IN-1:0] status_q
);
  logic [NUM_IN-1:0] prev_q;
  logic [NUM_IN-1:0] set_vec;

  // Per-line latch condition; only bits below NUM_IN of the kind mask are used.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    if (KIND_MASK[i]) begin : g_edge
      assign set_vec[i] = irq_in[i] & ~prev_q[i];
    end else begin : g_level
      assign set_vec[i] = irq_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= irq_in;
      status_q <= (status_q & ~ack_clr) | set_vec;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_clr & ~set_vec)) |=> ((status_q & $past(ack_clr & ~set_vec)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_IN = 8,
  parameter int IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] req,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  // Scan from the top down so the lowest set index is the last one written.
  always_comb begin
    idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |req;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          NUM_IN    = 8,
  parameter logic [31:0] KIND_MASK = 32'h0000_000F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq_req
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_IN-1:0] enable_q;
  logic [NUM_IN-1:0] enable_d;
  logic [NUM_IN-1:0] status_q;
  logic [NUM_IN-1:0] pend;
  logic [NUM_IN-1:0] ack_clr;
  logic [NUM_IN-1:0] wr_bits;
  logic [1:0]        master_q;
  logic              vec_hit;
  logic [IDX_W-1:0]  vec_idx;
  logic [31:0]       rd_mux;
  logic [31:0]       status_ext;
  logic [31:0]       pend_ext;
  logic [31:0]       enable_ext;
  logic              unused_wdata_bits;
  reg_addr_e         addr;

  assign addr              = reg_addr_e'(bus_addr);
  assign wr_bits           = bus_wdata[NUM_IN-1:0];
  assign unused_wdata_bits = ^bus_wdata;
  assign ack_clr           = (bus_wr && addr == RA_ACK) ? wr_bits : '0;

  irq_capture #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .ack_clr  (ack_clr),
    .status_q (status_q)
  );

  assign pend = status_q & enable_q;

  irq_prio_enc #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_prio (
    .req (pend),
    .hit (vec_hit),
    .idx (vec_idx)
  );

  always_comb begin
    enable_d = enable_q;
    if (bus_wr) begin
      case (addr)
        RA_ENABLE: enable_d = wr_bits;
        RA_SETEN:  enable_d = enable_q | wr_bits;
        RA_CLREN:  enable_d = enable_q & ~wr_bits;
        default:   enable_d = enable_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      master_q <= '0;
    end else begin
      enable_q <= enable_d;
      if (bus_wr && addr == RA_MASTER) master_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    status_ext = '0;
    pend_ext   = '0;
    enable_ext = '0;
    status_ext[NUM_IN-1:0] = status_q;
    pend_ext[NUM_IN-1:0]   = pend;
    enable_ext[NUM_IN-1:0] = enable_q;
    case (addr)
      RA_STATUS: rd_mux = status_ext;
      RA_PEND:   rd_mux = pend_ext;
      RA_ENABLE: rd_mux = enable_ext;
      RA_VECTOR: rd_mux = vec_hit ? 32'(vec_idx) : NO_VECTOR;
      RA_MASTER: rd_mux = {30'd0, master_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq_req = (master_q == 2'b11) && vec_hit;

  // R7
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (master_q == 2'b11 && (status_q & enable_q) != '0));

  // R6
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> (pend[vec_idx] && ((pend & ((NUM_IN'(1) << vec_idx) - NUM_IN'(1))) == '0)));

  // R3
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr == RA_SETEN) |=> ((enable_q & $past(wr_bits)) == $past(wr_bits)));

  // R3
  clr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr == RA_CLREN) |=> ((enable_q & $past(wr_bits)) == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_req && enable_q == '0 && master_q == 2'b00));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  import irq_vec_pkg::*;

  localparam int          CLK_PERIOD = 10;
  localparam int          NUM_IN     = 8;
  localparam logic [31:0] KIND       = 32'hFFFF_FF0F;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_IN-1:0] irq_in = '0;
  logic [2:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_rdata;
  logic              irq_req;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vector_ctrl #(.NUM_IN(NUM_IN), .KIND_MASK(KIND)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
  );

  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read data one edge after each read strobe.
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic wr_reg(reg_addr_e a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(reg_addr_e a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_in(logic [NUM_IN-1:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
    rd_exp(RA_STATUS, 32'h0, "R1 status");
    rd_exp(RA_ENABLE, 32'h0, "R1 enable");
    rd_exp(RA_MASTER, 32'h0, "R1 master");
    rd_exp(RA_VECTOR, 32'hFFFF_FFFF, "R1 vector");

    // R2 edge line 2 pulses once
    set_in(8'h04);
    set_in(8'h00);
    rd_exp(RA_STATUS, 32'h04, "R2 edge latch");
    rd_exp(RA_PEND, 32'h0, "R4 masked pending");
    rd_exp(RA_VECTOR, 32'hFFFF_FFFF, "R6 none pending");

    wr_reg(RA_SETEN, 32'h04);
    rd_exp(RA_ENABLE, 32'h04, "R3 set-enable");
    rd_exp(RA_PEND, 32'h04, "R4 pending");
    rd_exp(RA_VECTOR, 32'd2, "R6 vector 2");
    chk("R7 master off", {31'd0, irq_req}, 32'd0);
    wr_reg(RA_MASTER, 32'h1);
    chk("R7 only bit0", {31'd0, irq_req}, 32'd0);
    wr_reg(RA_MASTER, 32'h3);
    chk("R7 both bits", {31'd0, irq_req}, 32'd1);
    rd_exp(RA_MASTER, 32'h3, "R7 master readback");

    wr_reg(RA_ACK, 32'h04);
    chk("R5 req after ack", {31'd0, irq_req}, 32'd0);
    rd_exp(RA_STATUS, 32'h0, "R5 ack clears");

    // R8 level line 5 held across ack
    set_in(8'h20);
    wr_reg(RA_SETEN, 32'h20);
    rd_exp(RA_VECTOR, 32'd5, "R6 vector 5");
    wr_reg(RA_ACK, 32'h20);
    rd_exp(RA_STATUS, 32'h20, "R8 level relatch");
    set_in(8'h00);
    wr_reg(RA_ACK, 32'h20);
    rd_exp(RA_STATUS, 32'h0, "R8 level released");

    // R6 priority: edge line 1 and level line 6
    set_in(8'h42);
    set_in(8'h40);
    wr_reg(RA_ENABLE, 32'hFF);
    rd_exp(RA_VECTOR, 32'd1, "R6 lowest wins");
    wr_reg(RA_ACK, 32'h02);
    rd_exp(RA_VECTOR, 32'd6, "R6 next source");
    set_in(8'h00);
    wr_reg(RA_ACK, 32'h40);
    rd_exp(RA_STATUS, 32'h0, "R5 status clean");

    // R3 zero bits leave enable unchanged
    wr_reg(RA_ENABLE, 32'h30);
    wr_reg(RA_SETEN, 32'h01);
    rd_exp(RA_ENABLE, 32'h31, "R3 set keeps others");
    wr_reg(RA_CLREN, 32'h10);
    rd_exp(RA_ENABLE, 32'h21, "R3 clear keeps others");

    // R3 width, R4 enable zero masks all
    set_in(8'h08);
    set_in(8'h00);
    wr_reg(RA_ENABLE, 32'hFFFF_FFFF);
    rd_exp(RA_ENABLE, 32'h0000_00FF, "R3 enable width");
    rd_exp(RA_PEND, 32'h08, "R4 pending line 3");
    wr_reg(RA_ENABLE, 32'h0);
    rd_exp(RA_PEND, 32'h0, "R4 enable zero");
    rd_exp(RA_VECTOR, 32'hFFFF_FFFF, "R6 masked none");
    chk("R7 masked req", {31'd0, irq_req}, 32'd0);

    // R9 edge on line 0 coincides with its acknowledge
    set_in(8'h01);
    set_in(8'h00);
    rd_exp(RA_STATUS, 32'h09, "R2 edge line 0");
    @(negedge clk);
    irq_in = 8'h01; bus_addr = RA_ACK; bus_wdata = 32'h01; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_in = 8'h00;
    rd_exp(RA_STATUS, 32'h09, "R9 edge beats ack");

    // R5 acknowledge everything
    wr_reg(RA_ACK, 32'hFFFF_FFFF);
    rd_exp(RA_STATUS, 32'h0, "R5 ack all");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule